// File: doc/BRIEF.md
# Page Write Buffer and Write-Cycle Controller

This block sits between a two-wire serial slave engine and the storage array of a small nonvolatile memory. The engine first hands over an 11-bit word address, then strobes in data bytes one at a time. The block keeps those bytes in a 16-entry page buffer. The upper address bits select the page and stay fixed. A 4-bit column counter picks the buffer entry and wraps inside the page. A per-entry mask records which columns were actually loaded.

When the engine signals a Stop, the block starts a self-timed write cycle, provided write-protect is low and at least one byte was loaded. During the cycle, busy is high for a fixed number of system clocks, set by a parameter. In the first clocks of the cycle the loaded entries are written into a synchronous RAM model of the array, one per clock, in ascending column order. An abort, such as a repeated Start, discards the buffer. A Stop with nothing loaded does nothing. When the cycle finishes, the block reports the address that follows the last written byte, wrapped within the page. A read port on the array lets the surrounding logic fetch data and is not affected by write-protect.

Top module: `pgwr_top`

## Requirements
- R1: After reset, busy is low, no array write strobe is active and the reported pointer is 0.
- R2: Once a word address is loaded, each data byte goes into the buffer column given by address bits [3:0], and that column then advances by one. At commit, the byte goes to array address {word_addr[10:4], column}, and bits [10:4] never change within a sequence.
- R3: A sequence that starts mid-page and runs past column 15 continues at column 0 of the same page and never writes the next page.
- R4: If more than 16 bytes arrive before the Stop, later bytes overwrite earlier ones in arrival order. Only the last 16 bytes reach the array, and no cycle writes more than 16 locations.
- R5: Nothing is written to the array before the Stop, however long the gap between the last byte and the Stop.
- R6: If write-protect is high when the Stop arrives, no cycle starts, busy stays low and no array location changes. Reads still return stored data.
- R7: A committing Stop raises busy on the next clock edge, and busy then stays high for exactly WRITE_CLKS clocks.
- R8: Only the columns that were loaded are written. A single-byte sequence changes one location and leaves the rest of its page intact.
- R9: An abort before the Stop clears the buffer. A following Stop starts no cycle and changes no array location.
- R10: A Stop with no data byte loaded since the word address starts no cycle, and busy stays low.
- R11: When a cycle ends, the reported pointer becomes {page, column after the last loaded byte}. Because of the wrap, a full 16-byte page returns to column 0. The pointer holds steady while busy is high.
- R12: While busy is high, word-address loads, data bytes, Stops and aborts are all ignored. No second cycle follows, and no array location changes because of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp | input | 1 | Write-protect, sampled on the Stop strobe |
| load_addr | input | 1 | Strobe: word address is valid, opens a sequence |
| word_addr | input | 11 | Word address: page in [10:4], start column in [3:0] |
| byte_vld | input | 1 | Strobe: one received data byte |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | Stop strobe, requests the commit |
| abort | input | 1 | Abort strobe, discards the buffer |
| rd_addr | input | 11 | Array read address |
| busy | output | 1 | Write cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |
| rd_data | output | 8 | Array read data, one clock after rd_addr |
| ptr | output | 11 | Address pointer reported after a cycle |

## Verification
The bench drives several kinds of sequence. A full 16-byte page starting at column 0 shows a clean commit and the pointer wrapping back to column 0. A single byte shows that the mask leaves the rest of the page alone. A start at column 13 that runs past the page end shows the in-page wrap, and 20 bytes show that overwrites happen in arrival order. It also drives sequences that must not write: a delayed Stop, which separates buffering from committing; write-protect; abort; an empty Stop; and strobes injected during busy. In each of these cases, array readback and the busy line show whether anything leaked through.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    localparam int PGW_ADDR_W_DEF = 11;
    localparam int PGW_PAGE_DEF   = 16;
    localparam int PGW_DATA_W_DEF = 8;
    localparam int PGW_CLKS_DEF   = 40;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PROG = 2'd1,
        SQ_HOLD = 2'd2
    } sq_state_t;

    // Busy length actually used: the cycle must outlast the page scan.
    function automatic int hold_len(input int write_clks, input int page_bytes);
        return (write_clks > page_bytes) ? write_clks : page_bytes + 1;
    endfunction

endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = PGW_ADDR_W_DEF,
    parameter int PAGE_BYTES = PGW_PAGE_DEF,
    parameter int DATA_W     = PGW_DATA_W_DEF,
    localparam int COL_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - COL_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  byte_i,
    input  logic [DATA_W-1:0]     data_i,
    input  logic                  stop_i,
    input  logic                  abort_i,
    input  logic                  wp_i,
    input  logic                  busy_i,
    input  logic                  done_i,
    input  logic [COL_W-1:0]      rd_slot_i,
    output logic                  commit_o,
    output logic [PAGE_W-1:0]     page_o,
    output logic [COL_W-1:0]      col_o,
    output logic [PAGE_BYTES-1:0] mask_o,
    output logic [DATA_W-1:0]     rd_data_o
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  col;
    } cursor_t;

    cursor_t              cur;
    logic                 armed;
    logic [PAGE_BYTES-1:0] mask;
    logic [DATA_W-1:0]    slots [PAGE_BYTES];

    logic accept;
    logic take_byte;

    assign accept    = !busy_i;
    assign take_byte = accept && armed && byte_i && !abort_i && !load_i && !stop_i;
    assign commit_o  = accept && armed && stop_i && !abort_i && !load_i && !wp_i && (|mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            armed <= 1'b0;
            mask  <= '0;
        end else if (done_i) begin
            armed <= 1'b0;
            mask  <= '0;
        end else if (accept) begin
            if (abort_i) begin
                armed <= 1'b0;
                mask  <= '0;
            end else if (load_i) begin
                cur.page <= addr_i[ADDR_W-1:COL_W];
                cur.col  <= addr_i[COL_W-1:0];
                armed    <= 1'b1;
                mask     <= '0;
            end else if (stop_i) begin
                armed <= 1'b0;
                if (!commit_o) begin
                    mask <= '0;
                end
            end else if (take_byte) begin
                mask[cur.col] <= 1'b1;
                cur.col       <= cur.col + 1'b1;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < PAGE_BYTES; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (take_byte && (cur.col == COL_W'(g))) begin
                    slots[g] <= data_i;
                end
            end
        end
    endgenerate

    assign page_o    = cur.page;
    assign col_o     = cur.col;
    assign mask_o    = mask;
    assign rd_data_o = slots[rd_slot_i];

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int PAGE_BYTES = PGW_PAGE_DEF,
    parameter int WRITE_CLKS = PGW_CLKS_DEF,
    localparam int COL_W     = $clog2(PAGE_BYTES),
    localparam int CYC       = hold_len(WRITE_CLKS, PAGE_BYTES),
    localparam int TW        = $clog2(CYC + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  commit_i,
    input  logic [PAGE_BYTES-1:0] mask_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  we_o,
    output logic [COL_W-1:0]      slot_o
);

    sq_state_t       state;
    logic [TW-1:0]   timer;
    logic [COL_W-1:0] slot;
    logic            last_tick;

    assign last_tick = (state != SQ_IDLE) && (timer == TW'(CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            timer <= '0;
            slot  <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (commit_i) begin
                        state <= SQ_PROG;
                        timer <= '0;
                        slot  <= '0;
                    end
                end
                SQ_PROG: begin
                    timer <= timer + 1'b1;
                    slot  <= slot + 1'b1;
                    if (slot == COL_W'(PAGE_BYTES - 1)) begin
                        state <= SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    timer <= timer + 1'b1;
                    if (last_tick) begin
                        state <= SQ_IDLE;
                        timer <= '0;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o = (state != SQ_IDLE);
    assign done_o = last_tick;
    assign we_o   = (state == SQ_PROG) && mask_i[slot];
    assign slot_o = slot;

endmodule

// File: rtl/pgwr_ram.sv
module pgwr_ram
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = PGW_ADDR_W_DEF,
    parameter int DATA_W = PGW_DATA_W_DEF,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/pgwr_top.sv
module pgwr_top
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = PGW_ADDR_W_DEF,
    parameter int PAGE_BYTES = PGW_PAGE_DEF,
    parameter int DATA_W     = PGW_DATA_W_DEF,
    parameter int WRITE_CLKS = PGW_CLKS_DEF,
    localparam int COL_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop,
    input  logic              abort,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr
);

    logic                  commit;
    logic                  done;
    logic [PAGE_W-1:0]     page;
    logic [COL_W-1:0]      col;
    logic [PAGE_BYTES-1:0] mask;
    logic [COL_W-1:0]      slot;
    logic [DATA_W-1:0]     slot_data;

    pgwr_buffer #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)
    ) u_buf (
        .clk(clk), .rst(rst),
        .load_i(load_addr), .addr_i(word_addr),
        .byte_i(byte_vld), .data_i(byte_data),
        .stop_i(stop), .abort_i(abort), .wp_i(wp),
        .busy_i(busy), .done_i(done), .rd_slot_i(slot),
        .commit_o(commit), .page_o(page), .col_o(col),
        .mask_o(mask), .rd_data_o(slot_data)
    );

    pgwr_seq #(
        .PAGE_BYTES(PAGE_BYTES), .WRITE_CLKS(WRITE_CLKS)
    ) u_seq (
        .clk(clk), .rst(rst),
        .commit_i(commit), .mask_i(mask),
        .busy_o(busy), .done_o(done), .we_o(mem_we), .slot_o(slot)
    );

    assign mem_addr  = {page, slot};
    assign mem_wdata = slot_data;

    pgwr_ram #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ram (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (done) begin
            ptr <= {page, col};
        end
    end

endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = PGW_ADDR_W_DEF,
    parameter int PAGE_BYTES = PGW_PAGE_DEF,
    parameter int WRITE_CLKS = PGW_CLKS_DEF,
    localparam int COL_W     = $clog2(PAGE_BYTES),
    localparam int CYC       = hold_len(WRITE_CLKS, PAGE_BYTES)
) (
    input logic              clk,
    input logic              rst,
    input logic              wp,
    input logic              stop,
    input logic              abort,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] ptr
);

    int unsigned busy_cnt;
    int unsigned wr_cnt;
    logic        busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= 0;
            wr_cnt   <= 0;
            busy_q   <= 1'b0;
        end else begin
            busy_q   <= busy;
            busy_cnt <= busy ? busy_cnt + 1 : 0;
            wr_cnt   <= !busy ? 0 : (mem_we ? wr_cnt + 1 : wr_cnt);
        end
    end

    // R7: busy lasts exactly the configured number of clocks
    a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !busy) |-> (busy_cnt == CYC));

    // R5: array strobes only inside a write cycle
    a_r5_we_in_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R3: the write page never moves during a cycle
    a_r3_page_fixed: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:COL_W] == $past(mem_addr[ADDR_W-1:COL_W])));

    // R4: one cycle writes at most one page worth of locations
    a_r4_write_count: assert property (@(posedge clk) disable iff (rst)
        wr_cnt <= PAGE_BYTES);

    // R6: protected Stop starts no cycle
    a_r6_wp_blocks: assert property (@(posedge clk) disable iff (rst)
        (stop && wp && !busy) |=> !busy);

    // R9: abort starts no cycle
    a_r9_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        (abort && !busy) |=> !busy);

    // R11: pointer is steady during a cycle
    a_r11_ptr_steady: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ptr));

endmodule

bind pgwr_top pgwr_chk #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CLKS(WRITE_CLKS)
) chk_i (
    .clk(clk), .rst(rst), .wp(wp), .stop(stop), .abort(abort),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .ptr(ptr)
);

// File: tb/pgwr_top_tb_top.sv
module pgwr_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WCLK       = 40;

    logic        clk = 1'b0;
    logic        rst;
    logic        wp, load_addr, byte_vld, stop, abort;
    logic [10:0] word_addr, rd_addr;
    logic [7:0]  byte_data;
    logic        busy, mem_we;
    logic [10:0] mem_addr, ptr;
    logic [7:0]  mem_wdata, rd_data;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    typedef struct packed {
        logic [10:0] a;
        logic [7:0]  d;
    } wr_item_t;

    wr_item_t   exp_q [$];
    logic [7:0] shadow [2048];
    logic [7:0] img [16];
    bit         msk [16];
    logic [6:0] e_page;
    logic [3:0] e_col;
    bit         e_armed;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwr_top #(.WRITE_CLKS(WCLK)) dut_i (
        .clk(clk), .rst(rst), .wp(wp), .load_addr(load_addr), .word_addr(word_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop(stop), .abort(abort),
        .rd_addr(rd_addr), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rd_data(rd_data), .ptr(ptr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor: pops the scoreboard on every array write.
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_q.size() == 0) begin
                check(0, "R5", "unexpected write addr", int'(mem_addr), 0);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                check(mem_addr == it.a, "R2", "write addr", int'(mem_addr), int'(it.a));
                check(mem_wdata == it.d, "R3/R4", "write data", int'(mem_wdata), int'(it.d));
            end
        end
    end

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) ^ (i << 4));
    endfunction

    task automatic open_seq(input logic [10:0] a);
        word_addr = a; load_addr = 1'b1;
        @(negedge clk); load_addr = 1'b0;
        e_page = a[10:4]; e_col = a[3:0]; e_armed = 1;
        for (int s = 0; s < 16; s++) msk[s] = 0;
    endtask

    task automatic put_bytes(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            byte_data = pat(seed, i); byte_vld = 1'b1;
            @(negedge clk); byte_vld = 1'b0;
            if (e_armed) begin
                img[e_col] = pat(seed, i); msk[e_col] = 1; e_col = e_col + 4'd1;
            end
        end
    endtask

    task automatic do_abort();
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        e_armed = 0;
        for (int s = 0; s < 16; s++) msk[s] = 0;
    endtask

    // Stop: push expected writes (driver side) and measure the cycle.
    task automatic close_seq(input string req, input bit inject);
        bit any = 0;
        bit commit;
        int cnt = 0;
        logic [10:0] ptr_before;
        for (int s = 0; s < 16; s++) any |= msk[s];
        commit = e_armed && any && !wp;
        ptr_before = ptr;
        if (commit) begin
            for (int s = 0; s < 16; s++) begin
                if (msk[s]) begin
                    exp_q.push_back({{e_page, 4'(s)}, img[s]});
                    shadow[{e_page, 4'(s)}] = img[s];
                end
            end
        end
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        e_armed = 0;
        if (commit) begin
            while (busy && cnt < 4 * WCLK) begin
                cnt++;
                if (inject && cnt == 2) begin word_addr = 11'h053; load_addr = 1'b1; end
                if (inject && cnt == 3) begin load_addr = 1'b0; byte_data = 8'h99; byte_vld = 1'b1; end
                if (inject && cnt == 4) begin byte_vld = 1'b0; stop = 1'b1; end
                if (inject && cnt == 5) begin stop = 1'b0; abort = 1'b1; end
                if (inject && cnt == 6) abort = 1'b0;
                @(negedge clk);
            end
            check(cnt == WCLK, "R7", "busy length", cnt, WCLK);
            check(exp_q.size() == 0, "R2", "writes left pending", exp_q.size(), 0);
            check(ptr == {e_page, e_col}, "R11", "pointer", int'(ptr), int'({e_page, e_col}));
        end else begin
            repeat (WCLK + 4) begin
                @(negedge clk);
                if (busy) cnt++;
            end
            check(cnt == 0, req, "busy cycles without commit", cnt, 0);
            check(ptr == ptr_before, req, "pointer moved", int'(ptr), int'(ptr_before));
        end
        for (int s = 0; s < 16; s++) msk[s] = 0;
    endtask

    task automatic read_chk(input logic [10:0] a, input string req);
        rd_addr = a; @(negedge clk);
        check(rd_data == shadow[a], req, $sformatf("read @%0h", a),
              int'(rd_data), int'(shadow[a]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        rst = 1'b1; wp = 0; load_addr = 0; byte_vld = 0; stop = 0; abort = 0;
        word_addr = '0; byte_data = '0; rd_addr = '0;
        for (int i = 0; i < 2048; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(busy == 0, "R1", "busy after reset", busy, 0);
        check(mem_we == 0, "R1", "write strobe after reset", mem_we, 0);
        check(ptr == 0, "R1", "pointer after reset", int'(ptr), 0);

        // R2/R7/R11: full page from column 0, pointer wraps to column 0
        open_seq(11'h050); put_bytes(16, 1); close_seq("R2", 0);
        open_seq(11'h0A0); put_bytes(16, 2); close_seq("R2", 0);
        open_seq(11'h120); put_bytes(16, 3); close_seq("R2", 0);
        read_chk(11'h05F, "R2");

        // R8: single byte changes one location only
        open_seq(11'h053); put_bytes(1, 4); close_seq("R8", 0);
        read_chk(11'h052, "R8"); read_chk(11'h053, "R8"); read_chk(11'h054, "R8");

        // R3: mid-page start wraps inside the page
        open_seq(11'h0AD); put_bytes(5, 5); close_seq("R3", 0);
        read_chk(11'h0A0, "R3"); read_chk(11'h0A1, "R3"); read_chk(11'h0A2, "R3");
        check(ptr == 11'h0A2, "R3", "pointer after wrap", int'(ptr), 'h0A2);

        // R4: 20 bytes, last 16 survive
        open_seq(11'h0A4); put_bytes(20, 6); close_seq("R4", 0);
        read_chk(11'h0A4, "R4"); read_chk(11'h0A7, "R4"); read_chk(11'h0A8, "R4");

        // R5: long gap before Stop, nothing written yet
        open_seq(11'h126); put_bytes(3, 7);
        repeat (WCLK + 10) @(negedge clk);
        check(busy == 0, "R5", "busy before Stop", busy, 0);
        rd_addr = 11'h126; @(negedge clk);
        check(rd_data == 8'(pat(3, 6)), "R5", "early write @126", int'(rd_data), int'(pat(3, 6)));
        close_seq("R5", 0);
        read_chk(11'h126, "R5"); read_chk(11'h128, "R5");

        // R6: write-protect cancels the commit, reads still work
        wp = 1;
        open_seq(11'h122); put_bytes(4, 8); close_seq("R6", 0);
        read_chk(11'h122, "R6"); read_chk(11'h125, "R6");
        wp = 0;

        // R9: abort discards the buffer
        open_seq(11'h0A9); put_bytes(3, 9); do_abort(); close_seq("R9", 0);
        read_chk(11'h0A9, "R9");

        // R10: Stop after address only
        open_seq(11'h058); close_seq("R10", 0);
        read_chk(11'h058, "R10");

        // R12: strobes during busy are ignored
        open_seq(11'h12C); put_bytes(2, 10); close_seq("R12", 1);
        close_seq("R12", 0);
        read_chk(11'h053, "R12");
        check(ptr == 11'h12E, "R12", "pointer after ignored strobes", int'(ptr), 'h12E);

        done_flag = 1;
        report();
    end

endmodule